// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block supplies the next fetch address to an instruction fetch stage. The current fetch PC is looked up combinationally in a small direct-mapped table. Each entry holds a valid flag, an address tag, a predicted target and a 2-bit direction counter. When the tag matches and the counter leans toward taken, fetch is redirected to the stored target. In every other case fetch advances to PC+4.

A single training port is driven from the decode stage once a branch has been resolved. A resolved taken branch that misses claims the entry at its index, replacing whatever that entry held. A resolved branch that hits moves its counter toward its outcome and rewrites its target. Instructions are word aligned, so the two lowest PC bits never take part in the index or the tag.

Top module: `btb_direct`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses (`pred_hit_o`=0) and returns PC+4 until the first taken branch is trained.
- R2: The entry is selected by PC[5:2]. The hit test compares PC[31:6] with the stored tag, so two PCs with the same index and different tags never hit each other's entry.
- R3: On a hit whose counter has bit 1 set, `pred_taken_o`=1 and `next_pc_o` is the stored target (word aligned).
- R4: On a miss, or on a hit whose counter has bit 1 clear, `pred_taken_o`=0 and `next_pc_o`=`fetch_pc_i`+4.
- R5: A resolved taken branch that misses writes its tag and target into its index with the counter at weakly taken (2'b10). The next lookup of that PC hits and predicts taken.
- R6: Counter encoding is 00 strongly not taken, 01 weakly not taken, 10 weakly taken and 11 strongly taken. A resolved branch that hits increments its counter on taken, saturating at 11, and decrements it on not taken, saturating at 00.
- R7: A resolved not-taken branch that misses changes nothing, and its PC still misses afterwards.
- R8: A resolved branch that hits replaces the stored target with `upd_target_i`.
- R9: A training write lands at the clock edge. A lookup made in the same cycle, at the same index, returns the entry as it was before the write.
- R10: An allocation at an index that is occupied by a different tag evicts the old branch, so the old PC misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_pc_i | input | 32 | Current fetch PC |
| next_pc_o | output | 32 | Address to fetch next |
| pred_hit_o | output | 1 | Fetch PC matched a valid entry |
| pred_taken_o | output | 1 | Fetch is redirected to the stored target |
| upd_valid_i | input | 1 | A resolved branch is presented for training |
| upd_pc_i | input | 30 | Word address (PC[31:2]) of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |
| upd_target_i | input | 32 | Resolved target address |

## Verification
Lookup and training can act on the same entry in one cycle. The bench provokes this by presenting a fetch PC equal to the branch being trained. It does so both for an allocation into an empty slot and for a target rewrite of a live entry. The lookup in that cycle must show the old entry (a miss, or the old target), and the lookup of the same PC in the following cycle must show the new one. A scoreboard model, built from the requirements, applies the write only after computing that cycle's expected result, and it judges a long mixed sequence of lookups and trainings in which such collisions occur often.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  localparam ctr_e CTR_ALLOC = CTR_WT;

  function automatic ctr_e ctr_train(ctr_e c, logic taken);
    ctr_e r;
    if (taken) r = (c == CTR_ST)  ? CTR_ST  : ctr_e'(2'(c + 2'd1));
    else       r = (c == CTR_SNT) ? CTR_SNT : ctr_e'(2'(c - 2'd1));
    return r;
  endfunction

  function automatic logic ctr_says_taken(ctr_e c);
    return c[1];
  endfunction

endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic [ADDR_W-1:OFF_W] word_i,
  output logic [IDX_W-1:0]      idx_o,
  output logic [TAG_W-1:0]      tag_o
);

  assign idx_o = word_i[OFF_W+IDX_W-1:OFF_W];
  assign tag_o = word_i[ADDR_W-1:OFF_W+IDX_W];

endmodule

// File: rtl/btb_entry_array.sv
module btb_entry_array
  import btb_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int ADDR_W   = 32,
  parameter int TAG_W    = 26,
  parameter int RD_PORTS = 2,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i   [RD_PORTS],
  output logic              rd_valid_o [RD_PORTS],
  output logic [TAG_W-1:0]  rd_tag_o   [RD_PORTS],
  output logic [ADDR_W-1:0] rd_tgt_o   [RD_PORTS],
  output ctr_e              rd_ctr_o   [RD_PORTS],
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [ADDR_W-1:0] wr_tgt_i,
  input  ctr_e              wr_ctr_i
);

  logic              valid_q [ENTRIES];
  logic [TAG_W-1:0]  tag_q   [ENTRIES];
  logic [ADDR_W-1:0] tgt_q   [ENTRIES];
  ctr_e              ctr_q   [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[e] <= 1'b0;
        tag_q[e]   <= '0;
        tgt_q[e]   <= '0;
        ctr_q[e]   <= CTR_SNT;
      end else if (sel) begin
        valid_q[e] <= 1'b1;
        tag_q[e]   <= wr_tag_i;
        tgt_q[e]   <= wr_tgt_i;
        ctr_q[e]   <= wr_ctr_i;
      end
    end
  end

  // read ports see register state only: writes appear after the edge
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rd_valid_o[p] = valid_q[rd_idx_i[p]];
    assign rd_tag_o[p]   = tag_q[rd_idx_i[p]];
    assign rd_tgt_o[p]   = tgt_q[rd_idx_i[p]];
    assign rd_ctr_o[p]   = ctr_q[rd_idx_i[p]];
  end

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 26,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [TAG_W-1:0]  pc_tag_i,
  input  logic              ent_valid_i,
  input  logic [TAG_W-1:0]  ent_tag_i,
  input  logic [ADDR_W-1:0] ent_tgt_i,
  input  ctr_e              ent_ctr_i,
  output logic              hit_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] next_pc_o
);

  logic [ADDR_W-1:0] seq_pc;

  assign seq_pc    = pc_i + ADDR_W'(STEP);
  assign hit_o     = ent_valid_i && (ent_tag_i == pc_tag_i);
  assign taken_o   = hit_o && ctr_says_taken(ent_ctr_i);
  assign next_pc_o = taken_o ? ent_tgt_i : seq_pc;

endmodule

// File: rtl/btb_train.sv
module btb_train
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 26
) (
  input  logic              upd_valid_i,
  input  logic              upd_taken_i,
  input  logic [TAG_W-1:0]  upd_tag_i,
  input  logic [ADDR_W-1:0] upd_tgt_i,
  input  logic              ent_valid_i,
  input  logic [TAG_W-1:0]  ent_tag_i,
  input  ctr_e              ent_ctr_i,
  output logic              wr_en_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output logic [ADDR_W-1:0] wr_tgt_o,
  output ctr_e              wr_ctr_o
);

  logic ent_hit;

  assign ent_hit  = ent_valid_i && (ent_tag_i == upd_tag_i);
  // not-taken miss leaves the slot alone; taken miss evicts
  assign wr_en_o  = upd_valid_i && (ent_hit || upd_taken_i);
  assign wr_tag_o = upd_tag_i;
  assign wr_tgt_o = upd_tgt_i;
  assign wr_ctr_o = ent_hit ? ctr_train(ent_ctr_i, upd_taken_i) : CTR_ALLOC;

endmodule

// File: rtl/btb_direct.sv
module btb_direct
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  parameter int OFF_W   = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int STEP   = 1 << OFF_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     fetch_pc_i,
  output logic [ADDR_W-1:0]     next_pc_o,
  output logic                  pred_hit_o,
  output logic                  pred_taken_o,
  input  logic                  upd_valid_i,
  input  logic [ADDR_W-OFF_W-1:0] upd_pc_i,
  input  logic                  upd_taken_i,
  input  logic [ADDR_W-1:0]     upd_target_i
);

  localparam int P_FETCH = 0;
  localparam int P_UPD   = 1;

  logic [IDX_W-1:0]  rd_idx   [2];
  logic              rd_valid [2];
  logic [TAG_W-1:0]  rd_tag   [2];
  logic [ADDR_W-1:0] rd_tgt   [2];
  ctr_e              rd_ctr   [2];

  logic [TAG_W-1:0]  f_tag, u_tag;
  logic [IDX_W-1:0]  f_idx, u_idx;

  logic              wr_en;
  logic [TAG_W-1:0]  wr_tag;
  logic [ADDR_W-1:0] wr_tgt;
  ctr_e              wr_ctr;

  btb_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split_f (
    .word_i (fetch_pc_i[ADDR_W-1:OFF_W]),
    .idx_o  (f_idx),
    .tag_o  (f_tag)
  );

  btb_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split_u (
    .word_i (upd_pc_i),
    .idx_o  (u_idx),
    .tag_o  (u_tag)
  );

  assign rd_idx[P_FETCH] = f_idx;
  assign rd_idx[P_UPD]   = u_idx;

  btb_entry_array #(
    .ENTRIES (ENTRIES), .ADDR_W (ADDR_W), .TAG_W (TAG_W), .RD_PORTS (2)
  ) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (rd_idx),
    .rd_valid_o (rd_valid),
    .rd_tag_o   (rd_tag),
    .rd_tgt_o   (rd_tgt),
    .rd_ctr_o   (rd_ctr),
    .wr_en_i    (wr_en),
    .wr_idx_i   (u_idx),
    .wr_tag_i   (wr_tag),
    .wr_tgt_i   (wr_tgt),
    .wr_ctr_i   (wr_ctr)
  );

  btb_lookup #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .STEP(STEP)) u_lookup (
    .pc_i        (fetch_pc_i),
    .pc_tag_i    (f_tag),
    .ent_valid_i (rd_valid[P_FETCH]),
    .ent_tag_i   (rd_tag[P_FETCH]),
    .ent_tgt_i   (rd_tgt[P_FETCH]),
    .ent_ctr_i   (rd_ctr[P_FETCH]),
    .hit_o       (pred_hit_o),
    .taken_o     (pred_taken_o),
    .next_pc_o   (next_pc_o)
  );

  btb_train #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_train (
    .upd_valid_i (upd_valid_i),
    .upd_taken_i (upd_taken_i),
    .upd_tag_i   (u_tag),
    .upd_tgt_i   (upd_target_i),
    .ent_valid_i (rd_valid[P_UPD]),
    .ent_tag_i   (rd_tag[P_UPD]),
    .ent_ctr_i   (rd_ctr[P_UPD]),
    .wr_en_o     (wr_en),
    .wr_tag_o    (wr_tag),
    .wr_tgt_o    (wr_tgt),
    .wr_ctr_o    (wr_ctr)
  );

endmodule

// File: rtl/btb_direct_chk.sv
module btb_direct_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [ADDR_W-1:0]       fetch_pc_i,
  input logic [ADDR_W-1:0]       next_pc_o,
  input logic                    pred_hit_o,
  input logic                    pred_taken_o,
  input logic                    upd_valid_i,
  input logic [ADDR_W-OFF_W-1:0] upd_pc_i,
  input logic                    upd_taken_i,
  input logic [ADDR_W-1:0]       upd_target_i
);

  logic alloc_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         alloc_seen_q <= 1'b0;
    else if (upd_valid_i && upd_taken_i) alloc_seen_q <= 1'b1;
  end

  // R1
  cold_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alloc_seen_q |-> !pred_hit_o);

  // R4
  seq_on_no_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_taken_o |-> (next_pc_o == fetch_pc_i + ADDR_W'(1 << OFF_W)));

  // R3
  taken_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_taken_o |-> pred_hit_o);

  // R5
  trained_taken_hits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i) |=>
      ((fetch_pc_i[ADDR_W-1:OFF_W] == $past(upd_pc_i)) ->
        (pred_hit_o && (!pred_taken_o || next_pc_o == $past(upd_target_i)))));

  // R7
  nt_miss_no_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i && !pred_hit_o &&
     fetch_pc_i[ADDR_W-1:OFF_W] == upd_pc_i) |=>
      ((fetch_pc_i == $past(fetch_pc_i)) -> !pred_hit_o));

  // R9
  quiet_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> ($stable(fetch_pc_i) -> $stable(next_pc_o)));

endmodule

bind btb_direct btb_direct_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/sim_btb_direct.sv
`timescale 1ns/1ps
module sim_btb_direct;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] fetch_pc_i = '0;
  logic [31:0] next_pc_o;
  logic        pred_hit_o, pred_taken_o;
  logic        upd_valid_i = 1'b0;
  logic [29:0] upd_pc_i = '0;
  logic        upd_taken_i = 1'b0;
  logic [31:0] upd_target_i = '0;

  always #2.5 clk_i = ~clk_i;

  btb_direct u0 (.*);

  typedef struct {
    logic [31:0] nx;
    logic        hit;
    logic        tk;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model from the requirements
  logic        m_v   [16];
  logic [25:0] m_tag [16];
  logic [31:0] m_tgt [16];
  logic [1:0]  m_ctr [16];

  task automatic step(input logic [31:0] pc, input logic uv, input logic [31:0] upc,
                      input logic ut, input logic [31:0] utgt, input string req);
    item_t it;
    logic [3:0] fi, ui;
    logic uh;
    @(negedge clk_i);
    fetch_pc_i   = pc;
    upd_valid_i  = uv;
    upd_pc_i     = upc[31:2];
    upd_taken_i  = ut;
    upd_target_i = utgt;
    fi = pc[5:2];
    it.hit = m_v[fi] && (m_tag[fi] == pc[31:6]);
    it.tk  = it.hit && m_ctr[fi][1];
    it.nx  = it.tk ? m_tgt[fi] : pc + 32'd4;
    it.req = req;
    q.push_back(it);
    if (uv) begin
      ui = upc[5:2];
      uh = m_v[ui] && (m_tag[ui] == upc[31:6]);
      if (uh) begin
        if (ut && m_ctr[ui] != 2'b11) m_ctr[ui] = m_ctr[ui] + 2'd1;
        if (!ut && m_ctr[ui] != 2'b00) m_ctr[ui] = m_ctr[ui] - 2'd1;
        m_tgt[ui] = utgt;
      end else if (ut) begin
        m_v[ui] = 1'b1; m_tag[ui] = upc[31:6]; m_tgt[ui] = utgt; m_ctr[ui] = 2'b10;
      end
    end
  endtask

  task automatic look(input logic [31:0] pc, input string req);
    step(pc, 1'b0, 32'h0, 1'b0, 32'h0, req);
  endtask

  task automatic train(input logic [31:0] pc, input logic ut, input logic [31:0] tgt,
                       input string req);
    step(32'h0000_0F00, 1'b1, pc, ut, tgt, req);
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      @(negedge clk_i);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (next_pc_o !== it.nx || pred_hit_o !== it.hit || pred_taken_o !== it.tk) begin
          fails++;
          $display("FAIL %s: next=%h hit=%b tk=%b expected next=%h hit=%b tk=%b",
                   it.req, next_pc_o, pred_hit_o, pred_taken_o, it.nx, it.hit, it.tk);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  localparam logic [31:0] PA = 32'h0000_1040;  // idx 0
  localparam logic [31:0] PB = 32'h0000_1080;  // idx 0, other tag
  localparam logic [31:0] PC = 32'h0000_2004;  // idx 1
  localparam logic [31:0] PD = 32'h0000_3008;  // idx 2

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 16; i++) begin
      m_v[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = '0;
    end
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: cold lookups all miss
    look(32'h0000_0000, "R1");
    look(PA, "R1");
    look(32'hFFFF_FFFC, "R1");
    // R5: allocate taken miss, then hit weakly taken
    train(PA, 1'b1, 32'h0000_2000, "R5");
    look(PA, "R5");
    look(PA, "R3");
    // R6: saturate up then walk down
    train(PA, 1'b1, 32'h0000_2000, "R6");
    train(PA, 1'b1, 32'h0000_2000, "R6");
    train(PA, 1'b0, 32'h0000_2000, "R6");
    look(PA, "R6");
    train(PA, 1'b0, 32'h0000_2000, "R6");
    look(PA, "R4");
    train(PA, 1'b0, 32'h0000_2000, "R6");
    train(PA, 1'b0, 32'h0000_2000, "R6");
    train(PA, 1'b1, 32'h0000_2000, "R6");
    look(PA, "R6");
    train(PA, 1'b1, 32'h0000_2000, "R6");
    look(PA, "R6");
    // R2: same index, different tag misses
    look(PB, "R2");
    // R7: not-taken miss does not allocate
    train(PC, 1'b0, 32'h0000_4000, "R7");
    look(PC, "R7");
    // R8: hit rewrites target
    train(PA, 1'b1, 32'h0000_5550, "R8");
    look(PA, "R8");
    // R9: same-cycle lookup sees old contents
    step(PA, 1'b1, PA, 1'b1, 32'h0000_6660, "R9");
    look(PA, "R9");
    step(PD, 1'b1, PD, 1'b1, 32'h0000_7770, "R9");
    look(PD, "R9");
    // R10: eviction by conflicting tag
    train(PB, 1'b1, 32'h0000_8880, "R10");
    look(PB, "R10");
    look(PA, "R10");
    // mixed traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] fpc, upc;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fpc = {22'h4, lfsr[7:0], 2'b00};
      upc = {22'h4, lfsr[3:0], lfsr[11:8], 2'b00};
      step(fpc, lfsr[12], upc, lfsr[13] | lfsr[14], {16'h9, lfsr[15:2], 2'b00}, "R3");
    end
    look(32'h0000_0000, "R4");
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule